// File: doc/BRIEF.md
# Scan Chain with Freezable Functional Outputs

This block is a serial test chain of storage cells. Each cell either loads a bit from the parallel functional input or takes the bit from the cell before it, so the whole chain behaves as a shift register during test. Alongside the serial path, every cell drives a functional output toward downstream logic. That output passes through a second register that a freeze control can stop.

The freeze exists so that the cells can shift while the logic they feed sees no activity. It keeps switching in that logic low during long shift sequences, and it shields logic that must not see scan traffic. The serial path never stops. The last cell's contents appear on the serial output, so a pattern can be moved through the chain while the functional outputs stay at the value they last presented.

The design is fully synchronous. It uses one clock and a synchronous active-high reset.

Top module: `scan_hold_chain`

## Requirements
- R1: Reset is synchronous and active high. An edge with `rst` high clears every internal cell, every functional output in `par_q` and `scan_out` to 0.
- R2: With `scan_en` low, cell i loads `par_d[i]` at the clock edge.
- R3: With `scan_en` high, cell 0 loads `scan_in` and cell i (i ≥ 1) loads the previous contents of cell i-1 at the clock edge.
- R4: `scan_out` always equals the contents of the last cell, index CHAIN_LEN-1.
- R5: While `hold_en` is high at a clock edge, `par_q` keeps the value it had before that edge. This applies whether the cells are shifting or loading.
- R6: While `hold_en` is high, shifting goes on unchanged. `scan_out` presents the successive contents of the last cell exactly as it would with `hold_en` low.
- R7: At an edge with `hold_en` low, `par_q` takes the value that the cells load at that same edge. When the hold drops, the functional outputs therefore catch up with the chain at the next edge.
- R8: Across a full shift of at least CHAIN_LEN cycles with `hold_en` high, no bit of `par_q` toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | 1: shift the serial path; 0: load the functional input |
| hold_en | input | 1 | 1: freeze the functional outputs |
| scan_in | input | 1 | Serial input to cell 0 |
| par_d | input | CHAIN_LEN | Functional input, bit i goes to cell i |
| par_q | output | CHAIN_LEN | Frozen-or-tracking functional output, bit i from cell i |
| scan_out | output | 1 | Contents of the last cell |

## Verification
The hardest condition to bring about is a divergence between the internal cells and the functional outputs. The ports show the cells only one bit at a time, through `scan_out`. The stimulus therefore first loads a known word with the freeze off, then raises the freeze and shifts a different pattern through twice the chain length. Along the way it checks `par_q` against the frozen word on every cycle and `scan_out` against a bench-side model of the chain. Finally it drops the freeze during a shift, so the whole hidden state shows up on `par_q` in one edge.

// File: rtl/shc_pkg.sv
package shc_pkg;

    // Control bundle applied to every cell on a clock edge.
    typedef struct packed {
        logic shift;   // 1: take serial input, 0: take functional input
        logic freeze;  // 1: functional output keeps its value
    } shc_ctrl_t;

    // Value a cell stores at the next edge.
    function automatic logic cell_next(input shc_ctrl_t c,
                                       input logic func_bit,
                                       input logic ser_bit);
        return c.shift ? ser_bit : func_bit;
    endfunction

    // Value a functional output register stores at the next edge.
    function automatic logic hold_next(input shc_ctrl_t c,
                                       input logic cur,
                                       input logic fresh);
        return c.freeze ? cur : fresh;
    endfunction

endpackage

// File: rtl/shc_cell.sv
module shc_cell
    import shc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shc_ctrl_t  ctrl,
    input  logic       func_in,
    input  logic       ser_in,
    output logic       nxt,
    output logic       ser_out
);
    logic state_q;

    always_comb nxt = cell_next(ctrl, func_in, ser_in);

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else     state_q <= nxt;
    end

    assign ser_out = state_q;
endmodule

// File: rtl/shc_hold_reg.sv
module shc_hold_reg
    import shc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shc_ctrl_t  ctrl,
    input  logic       fresh,
    output logic       q_out
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= hold_next(ctrl, held_q, fresh);
    end

    assign q_out = held_q;
endmodule

// File: rtl/scan_hold_chain.sv
module scan_hold_chain
    import shc_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic                 hold_en,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] par_d,
    output logic [CHAIN_LEN-1:0] par_q,
    output logic                 scan_out
);
    localparam int LAST = CHAIN_LEN - 1;

    shc_ctrl_t              ctrl;
    logic [CHAIN_LEN-1:0]   ser;   // internal contents of each cell
    logic [CHAIN_LEN-1:0]   nxt;   // value each cell loads next edge
    logic [CHAIN_LEN:0]     link;  // serial links, link[0] = scan_in

    always_comb begin
        ctrl.shift  = scan_en;
        ctrl.freeze = hold_en;
    end

    assign link[0] = scan_in;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        shc_cell cell_i (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl),
            .func_in (par_d[i]),
            .ser_in  (link[i]),
            .nxt     (nxt[i]),
            .ser_out (ser[i])
        );
        assign link[i+1] = ser[i];

        shc_hold_reg hold_i (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl),
            .fresh (nxt[i]),
            .q_out (par_q[i])
        );
    end

    assign scan_out = link[LAST+1];
endmodule

// File: rtl/shc_chk.sv
module shc_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         scan_en,
    input logic         hold_en,
    input logic         scan_in,
    input logic [N-1:0] par_d,
    input logic [N-1:0] par_q,
    input logic         scan_out
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (par_q == '0 && scan_out == 1'b0));

    // R5
    frozen_output_chk: assert property (@(posedge clk) disable iff (rst)
        hold_en |=> $stable(par_q));

    // R2
    func_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !hold_en) |=> (par_q == $past(par_d)));

    // R3
    first_cell_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !hold_en) |=> (par_q[0] == $past(scan_in)));

    // R4
    last_cell_out_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_en |=> (scan_out == par_q[N-1]));
endmodule

bind scan_hold_chain shc_chk #(.N(CHAIN_LEN)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .scan_en  (scan_en),
    .hold_en  (hold_en),
    .scan_in  (scan_in),
    .par_d    (par_d),
    .par_q    (par_q),
    .scan_out (scan_out)
);

// File: tb/scan_hold_chain_tb_top.sv
module scan_hold_chain_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scan_en = 1'b0;
    logic         hold_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] par_q;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scan_hold_chain #(.CHAIN_LEN(W)) dut_i (
        .clk(clk), .rst(rst), .scan_en(scan_en), .hold_en(hold_en),
        .scan_in(scan_in), .par_d(par_d), .par_q(par_q), .scan_out(scan_out)
    );

    // {scan_en, hold_en, scan_in, par_d[7:0], exp_par_q[7:0], exp_scan_out}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b1},  // R2 load, R7 track
        {1'b0, 1'b1, 1'b0, 8'h3C, 8'hA5, 1'b0},  // R5 frozen while loading
        {1'b1, 1'b1, 1'b1, 8'h00, 8'hA5, 1'b0},  // R3/R6 shift -> 79
        {1'b1, 1'b1, 1'b0, 8'h00, 8'hA5, 1'b1},  // shift -> F2
        {1'b1, 1'b0, 1'b1, 8'h00, 8'hE5, 1'b1},  // R7 release -> E5
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},  // R2 all zero
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b1},  // R2 all one, R4
        {1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1}   // R5/R6 shift -> FE
    };

    task automatic check_q(input string req, input logic [W-1:0] exp);
        checks++;
        if (par_q !== exp) begin
            errors++;
            $display("FAIL %s par_q actual %h expected %h", req, par_q, exp);
        end
    endtask

    task automatic check_so(input string req, input logic exp);
        checks++;
        if (scan_out !== exp) begin
            errors++;
            $display("FAIL %s scan_out actual %b expected %b", req, scan_out, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [W-1:0] model;
        logic [W-1:0] frozen;
        logic [15:0]  pat;
        pat = 16'h5A3C;

        tick;
        tick;
        // R1: reset state
        check_q("R1", '0);
        check_so("R1", 1'b0);
        rst = 1'b0;

        // Table walk
        for (int k = 0; k < 8; k++) begin
            {scan_en, hold_en, scan_in, par_d} = VEC[k][19:9];
            tick;
            check_q("R2/R3/R5/R7", VEC[k][8:1]);
            check_so("R4/R6", VEC[k][0]);
        end

        // R8: full shift under hold, twice the chain length
        scan_en = 1'b0; hold_en = 1'b0; par_d = 8'h96;
        tick;
        check_q("R2", 8'h96);
        model = 8'h96;
        frozen = 8'h96;
        scan_en = 1'b1; hold_en = 1'b1;
        for (int k = 0; k < 2*W; k++) begin
            scan_in = pat[k];
            par_d = ~par_d;
            tick;
            model = {model[W-2:0], pat[k]};
            check_q("R8", frozen);
            check_so("R6", model[W-1]);
        end

        // R7: release hold during shift exposes the whole chain
        hold_en = 1'b0; scan_in = 1'b1;
        tick;
        model = {model[W-2:0], 1'b1};
        check_q("R7", model);
        check_so("R4", model[W-1]);

        // R1: reset in the middle of operation
        scan_en = 1'b0; par_d = 8'hFF;
        tick;
        check_q("R2", 8'hFF);
        rst = 1'b1;
        tick;
        check_q("R1", '0);
        check_so("R1", 1'b0);
        rst = 1'b0; hold_en = 1'b1;
        tick;
        check_q("R5", '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule